// File: doc/BRIEF.md
# E1 Timeslot 16 Common-Channel Signalling Port

This block handles timeslot 16 of a 32-timeslot E1 frame while the link carries common channel signalling. On the transmit side it passes the main serial line stream through. When signalling mode is on and the serial source is selected, it replaces the eight timeslot 16 bits with a byte taken from a dedicated 64 kbit/s serial input. That input is timed by a 64 kHz clock that the block derives by counting enables of the 4.096 MHz system clock, one block-clock cycle per enable. On the receive side it captures the timeslot 16 byte from the recovered line stream. It then presents the byte MSB first on a serial output, next to a 64 kHz clock derived from the recovered 2.048 MHz clock enable.

Both dividers run from frame position counters. Each side has a frame-sync input that realigns its counter, so every 64 kHz period carries exactly one bit and eight periods span one frame. A byte collected during one frame is used in the following frame. Mode inputs are latched only at frame boundaries, so a frame is never split between two sources.

Top module: `ccs16_port`

## Requirements
- R1: While reset is held, and after release until the first enable, tx_ck64 and rx_ck64 are 1, rx_ser_out is 1 and tx_line_out equals tx_main_in.
- R2: The transmit position p advances by one, modulo 512, on each clock edge with sys_ce high. tx_ck64 is 1 exactly when p mod 64 < 32, giving eight periods per frame with rising edges at multiples of 64.
- R3: tx_ser_in is shifted in on enabled edges where p mod 64 = 0, the first sample being the MSB. At each transmit frame boundary the last eight samples become the byte sent in the next frame. That byte's bit 7-k occupies positions 256+2k and 257+2k (timeslot 16).
- R4: Outside positions 256..271, or when the latched mode is not both signalling-on and serial-source, tx_line_out equals tx_main_in.
- R5: ccs_en and ser_src_sel are latched only at frame boundaries. A change in mid-frame has no effect on the outputs until the next frame.
- R6: The receive position q advances by one, modulo 256, on each edge with rec_ce high. rx_ck64 is 1 exactly when q mod 32 < 16.
- R7: rx_line_in is captured on enabled edges at q = 128..135, MSB first. The byte moves to the output at the receive frame boundary. In the next frame rx_ser_out carries bit 7-(q div 32) while the latched ccs_en is 1.
- R8: In a receive frame whose latched ccs_en is 0, rx_ser_out is held at 1.
- R9: An enabled edge with the side's frame-sync input high makes that side's next position 0 and performs the frame-boundary transfer and mode latch at once.
- R10: With the side's enable low, that side's position, clock output, stored bytes and latched mode do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ccs_en | input | 1 | Common channel signalling mode enable |
| ser_src_sel | input | 1 | 1: timeslot 16 from tx_ser_in; 0: from main stream |
| sys_ce | input | 1 | 4.096 MHz system clock enable |
| tx_frame_sync | input | 1 | Transmit realign: next position is 0 |
| tx_main_in | input | 1 | Main transmit line stream |
| tx_ser_in | input | 1 | Dedicated 64 kbit/s transmit serial input |
| tx_line_out | output | 1 | Transmit line stream with timeslot 16 applied |
| tx_ck64 | output | 1 | 64 kHz transmit serial clock |
| rec_ce | input | 1 | Recovered 2.048 MHz clock enable |
| rx_frame_sync | input | 1 | Receive realign: next position is 0 |
| rx_line_in | input | 1 | Recovered receive line stream |
| rx_ser_out | output | 1 | Receive timeslot 16 serial output |
| rx_ck64 | output | 1 | 64 kHz receive serial clock |

## Verification
The bench builds the block with its defaults: 8-bit timeslots, 32 timeslots per frame, timeslot 16 and two system ticks per line bit. In that configuration a sweep of 256 transmit frames feeds every possible serial byte value through the timeslot, with mode changes placed in mid-frame. A second phase gates both enables with unrelated patterns and realigns each side in mid-frame. Every output is compared in every cycle against a position-and-shift model built from the requirements.

// File: rtl/ccs16_pkg.sv
package ccs16_pkg;

  // Transmit-side mode latched at each frame boundary.
  typedef struct packed {
    logic ccs;      // common channel signalling on
    logic ser_src;  // timeslot 16 comes from the serial input
  } ccs16_mode_t;

endpackage

// File: rtl/ccs16_frame_ctr.sv
module ccs16_frame_ctr #(
  parameter int unsigned LEN = 256,
  parameter int unsigned W   = $clog2(LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         sync,
  output logic [W-1:0] pos,
  output logic         bound
);

  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] pos_q;
  logic [W-1:0] pos_nxt;

  // A boundary is an enabled edge at the last position or on realign.
  always_comb begin
    bound   = ce && (sync || (pos_q == LAST));
    pos_nxt = pos_q;
    if (ce) begin
      if (bound) pos_nxt = '0;
      else       pos_nxt = pos_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nxt;
  end

  assign pos = pos_q;

endmodule

// File: rtl/ccs16_tx_path.sv
module ccs16_tx_path
  import ccs16_pkg::*;
#(
  parameter  int unsigned TS_BITS  = 8,
  parameter  int unsigned FRAME_TS = 32,
  parameter  int unsigned TS_SEL   = 16,
  parameter  int unsigned OSR      = 2,
  localparam int unsigned TX_LEN   = TS_BITS * FRAME_TS * OSR,
  localparam int unsigned W        = $clog2(TX_LEN)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce,
  input  logic        sync,
  input  ccs16_mode_t mode_in,
  input  logic        main_in,
  input  logic        ser_in,
  output logic        line_out,
  output logic        ck64,
  output logic [W-1:0] pos,
  output ccs16_mode_t mode_q
);

  localparam int unsigned DIV      = TX_LEN / TS_BITS;
  localparam int unsigned DIV_W    = $clog2(DIV);
  localparam int unsigned OSR_W    = $clog2(OSR);
  localparam int unsigned BW       = $clog2(TS_BITS);
  localparam int unsigned SLOT_TK  = TS_BITS * OSR;
  localparam logic [W-1:0] SLOT_START = W'(TS_SEL * SLOT_TK);
  localparam logic [W-1:0] SLOT_SPAN  = W'(SLOT_TK);
  localparam logic [BW-1:0] TOP_IDX   = BW'(TS_BITS - 1);

  logic [W-1:0]       pos_w;
  logic               bound;
  logic [TS_BITS-1:0] shift_q, shift_nxt;
  logic [TS_BITS-1:0] hold_q, hold_nxt;
  ccs16_mode_t        mode_r, mode_nxt;
  logic               take;
  logic [W-1:0]       rel;
  logic               in_slot;
  logic [BW-1:0]      bidx;

  ccs16_frame_ctr #(.LEN(TX_LEN), .W(W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .sync  (sync),
    .pos   (pos_w),
    .bound (bound)
  );

  // Next state: sample at each 64 kHz rising edge, hand over at boundary.
  always_comb begin
    take      = ce && (pos_w[DIV_W-1:0] == '0);
    shift_nxt = shift_q;
    if (take) shift_nxt = {shift_q[TS_BITS-2:0], ser_in};
    hold_nxt  = bound ? shift_q : hold_q;
    mode_nxt  = bound ? mode_in : mode_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      hold_q  <= '1;
      mode_r  <= '0;
    end else begin
      shift_q <= shift_nxt;
      hold_q  <= hold_nxt;
      mode_r  <= mode_nxt;
    end
  end

  // Output selection inside the timeslot 16 window.
  always_comb begin
    rel      = pos_w - SLOT_START;
    in_slot  = (rel < SLOT_SPAN);
    bidx     = BW'(rel >> OSR_W);
    line_out = main_in;
    if (mode_r.ccs && mode_r.ser_src && in_slot)
      line_out = hold_q[TOP_IDX - bidx];
  end

  assign ck64   = ~pos_w[DIV_W-1];
  assign pos    = pos_w;
  assign mode_q = mode_r;

endmodule

// File: rtl/ccs16_rx_path.sv
module ccs16_rx_path #(
  parameter  int unsigned TS_BITS  = 8,
  parameter  int unsigned FRAME_TS = 32,
  parameter  int unsigned TS_SEL   = 16,
  localparam int unsigned RX_LEN   = TS_BITS * FRAME_TS,
  localparam int unsigned W        = $clog2(RX_LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         sync,
  input  logic         ccs_in,
  input  logic         line_in,
  output logic         ser_out,
  output logic         ck64,
  output logic [W-1:0] pos,
  output logic         ccs_q
);

  localparam int unsigned DIV   = RX_LEN / TS_BITS;
  localparam int unsigned DIV_W = $clog2(DIV);
  localparam int unsigned BW    = $clog2(TS_BITS);
  localparam logic [W-1:0]  CAP_START = W'(TS_SEL * TS_BITS);
  localparam logic [W-1:0]  CAP_SPAN  = W'(TS_BITS);
  localparam logic [BW-1:0] TOP_IDX   = BW'(TS_BITS - 1);

  logic [W-1:0]       pos_w;
  logic               bound;
  logic [TS_BITS-1:0] cap_q, cap_nxt;
  logic [TS_BITS-1:0] obuf_q, obuf_nxt;
  logic               ccs_r, ccs_nxt;
  logic [W-1:0]       rel;
  logic               take;
  logic [BW-1:0]      slot;

  ccs16_frame_ctr #(.LEN(RX_LEN), .W(W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .sync  (sync),
    .pos   (pos_w),
    .bound (bound)
  );

  always_comb begin
    rel     = pos_w - CAP_START;
    take    = ce && (rel < CAP_SPAN);
    cap_nxt = cap_q;
    if (take) cap_nxt = {cap_q[TS_BITS-2:0], line_in};
    obuf_nxt = bound ? cap_q  : obuf_q;
    ccs_nxt  = bound ? ccs_in : ccs_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '1;
      obuf_q <= '1;
      ccs_r  <= 1'b0;
    end else begin
      cap_q  <= cap_nxt;
      obuf_q <= obuf_nxt;
      ccs_r  <= ccs_nxt;
    end
  end

  // One output bit per 64 kHz period, MSB in the first period.
  always_comb begin
    slot    = pos_w[W-1:DIV_W];
    ser_out = ccs_r ? obuf_q[TOP_IDX - slot] : 1'b1;
  end

  assign ck64  = ~pos_w[DIV_W-1];
  assign pos   = pos_w;
  assign ccs_q = ccs_r;

endmodule

// File: rtl/ccs16_port.sv
module ccs16_port
  import ccs16_pkg::*;
#(
  parameter  int unsigned TS_BITS  = 8,
  parameter  int unsigned FRAME_TS = 32,
  parameter  int unsigned TS_SEL   = 16,
  parameter  int unsigned OSR      = 2,
  localparam int unsigned TX_LEN   = TS_BITS * FRAME_TS * OSR,
  localparam int unsigned RX_LEN   = TS_BITS * FRAME_TS,
  localparam int unsigned TX_W     = $clog2(TX_LEN),
  localparam int unsigned RX_W     = $clog2(RX_LEN),
  localparam int unsigned TX_DW    = $clog2(TX_LEN / TS_BITS),
  localparam int unsigned RX_DW    = $clog2(RX_LEN / TS_BITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ccs_en,
  input  logic ser_src_sel,
  input  logic sys_ce,
  input  logic tx_frame_sync,
  input  logic tx_main_in,
  input  logic tx_ser_in,
  output logic tx_line_out,
  output logic tx_ck64,
  input  logic rec_ce,
  input  logic rx_frame_sync,
  input  logic rx_line_in,
  output logic rx_ser_out,
  output logic rx_ck64
);

  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  ccs16_mode_t     mode_in;
  ccs16_mode_t     tx_mode;
  logic [TX_W-1:0] tx_pos;
  logic [RX_W-1:0] rx_pos;
  logic            rx_ccs;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    mode_in.ccs     = ccs_en;
    mode_in.ser_src = ser_src_sel;
  end

  ccs16_tx_path #(
    .TS_BITS (TS_BITS),
    .FRAME_TS(FRAME_TS),
    .TS_SEL  (TS_SEL),
    .OSR     (OSR)
  ) tx_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce      (sys_ce),
    .sync    (tx_frame_sync),
    .mode_in (mode_in),
    .main_in (tx_main_in),
    .ser_in  (tx_ser_in),
    .line_out(tx_line_out),
    .ck64    (tx_ck64),
    .pos     (tx_pos),
    .mode_q  (tx_mode)
  );

  ccs16_rx_path #(
    .TS_BITS (TS_BITS),
    .FRAME_TS(FRAME_TS),
    .TS_SEL  (TS_SEL)
  ) rx_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ce     (rec_ce),
    .sync   (rx_frame_sync),
    .ccs_in (ccs_en),
    .line_in(rx_line_in),
    .ser_out(rx_ser_out),
    .ck64   (rx_ck64),
    .pos    (rx_pos),
    .ccs_q  (rx_ccs)
  );

endmodule

// File: rtl/ccs16_port_chk.sv
module ccs16_port_chk #(
  parameter int unsigned TX_LEN = 512,
  parameter int unsigned TX_W   = 9,
  parameter int unsigned TX_DW  = 6,
  parameter int unsigned RX_W   = 8,
  parameter int unsigned RX_DW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sys_ce,
  input logic            rec_ce,
  input logic            tx_frame_sync,
  input logic            tx_ck64,
  input logic            rx_ck64,
  input logic [TX_W-1:0] tx_pos,
  input logic [RX_W-1:0] rx_pos,
  input logic [1:0]      tx_mode,
  input logic            rx_ccs
);

  localparam logic [TX_W-1:0] TX_LAST = TX_W'(TX_LEN - 1);

  // R2: transmit serial clock rises only at a bit boundary
  assert_tx_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ck64) |-> (tx_pos[TX_DW-1:0] == '0));

  // R6: receive serial clock rises only at a bit boundary
  assert_rx_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ck64) |-> (rx_pos[RX_DW-1:0] == '0));

  // R5: latched mode moves only on a frame boundary
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_ce && (tx_frame_sync || (tx_pos == TX_LAST))) |=> $stable(tx_mode));

  // R9: realign restarts the transmit frame
  assert_tx_realign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ce && tx_frame_sync) |=> (tx_pos == '0));

  // R10: no transmit enable, no movement
  assert_tx_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ce |=> ($stable(tx_pos) && $stable(tx_ck64)));

  // R10: no receive enable, no movement
  assert_rx_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_ce |=> ($stable(rx_pos) && $stable(rx_ck64) && $stable(rx_ccs)));

endmodule

bind ccs16_port ccs16_port_chk #(
  .TX_LEN(TX_LEN),
  .TX_W  (TX_W),
  .TX_DW (TX_DW),
  .RX_W  (RX_W),
  .RX_DW (RX_DW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sys_ce       (sys_ce),
  .rec_ce       (rec_ce),
  .tx_frame_sync(tx_frame_sync),
  .tx_ck64      (tx_ck64),
  .rx_ck64      (rx_ck64),
  .tx_pos       (tx_pos),
  .rx_pos       (rx_pos),
  .tx_mode      (tx_mode),
  .rx_ccs       (rx_ccs)
);

// File: tb/ccs16_port_tb_top.sv
`timescale 1ns/1ps
module ccs16_port_tb_top;

  logic clk;
  logic rst_n;
  logic ccs_en, ser_src_sel, sys_ce, tx_frame_sync, tx_main_in, tx_ser_in;
  logic rec_ce, rx_frame_sync, rx_line_in;
  logic tx_line_out, tx_ck64, rx_ser_out, rx_ck64;

  int checks;
  int failures;
  bit done;

  ccs16_port dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ccs_en       (ccs_en),
    .ser_src_sel  (ser_src_sel),
    .sys_ce       (sys_ce),
    .tx_frame_sync(tx_frame_sync),
    .tx_main_in   (tx_main_in),
    .tx_ser_in    (tx_ser_in),
    .tx_line_out  (tx_line_out),
    .tx_ck64      (tx_ck64),
    .rec_ce       (rec_ce),
    .rx_frame_sync(rx_frame_sync),
    .rx_line_in   (rx_line_in),
    .rx_ser_out   (rx_ser_out),
    .rx_ck64      (rx_ck64)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model state, computed from the requirements.
  int       mp, mq;           // frame positions
  logic [7:0] m_tsh, m_thold; // transmit shift / hold
  logic [7:0] m_rsh, m_robuf; // receive capture / output
  logic     m_tccs, m_tsrc, m_rccs;
  bit       tx_stalled, rx_stalled, tx_after_sync, rx_after_sync;
  int       tx_frame, rx_frame;

  function automatic logic hbit(input int unsigned x, input int s);
    logic [31:0] h;
    h = x * 32'h9E3779B1 + 32'h1234567;
    return h[s];
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b tx_pos=%0d rx_pos=%0d t=%0t",
               req, act, exp, mp, mq, $time);
    end
  endtask

  task automatic check_outputs();
    logic e_line, e_rx;
    string tag;
    check1(tx_stalled ? "R10" : "R2", tx_ck64, ((mp % 64) < 32));
    check1(rx_stalled ? "R10" : "R6", rx_ck64, ((mq % 32) < 16));
    if (m_tccs && m_tsrc && mp >= 256 && mp < 272) begin
      e_line = m_thold[7 - ((mp - 256) >> 1)];
      if (tx_after_sync) tag = "R9";
      else if (ccs_en != m_tccs || ser_src_sel != m_tsrc) tag = "R5";
      else tag = "R3";
    end else begin
      e_line = tx_main_in;
      tag = "R4";
    end
    check1(tag, tx_line_out, e_line);
    if (m_rccs) begin
      e_rx = m_robuf[7 - (mq >> 5)];
      tag = rx_after_sync ? "R9" : "R7";
    end else begin
      e_rx = 1'b1;
      tag = "R8";
    end
    check1(tag, rx_ser_out, e_rx);
  endtask

  // Model update for one clock edge, from the inputs driven this cycle.
  task automatic model_edge();
    bit bnd;
    tx_stalled = !sys_ce;
    rx_stalled = !rec_ce;
    if (sys_ce) begin
      bnd = tx_frame_sync || (mp == 511);
      if (bnd) begin
        m_thold = m_tsh;
        m_tccs  = ccs_en;
        m_tsrc  = ser_src_sel;
        tx_after_sync = tx_frame_sync;
        tx_frame++;
      end
      if ((mp % 64) == 0) m_tsh = {m_tsh[6:0], tx_ser_in};
      mp = bnd ? 0 : mp + 1;
    end
    if (rec_ce) begin
      bnd = rx_frame_sync || (mq == 255);
      if (bnd) begin
        m_robuf = m_rsh;
        m_rccs  = ccs_en;
        rx_after_sync = rx_frame_sync;
        rx_frame++;
      end
      if (mq >= 128 && mq < 136) m_rsh = {m_rsh[6:0], rx_line_in};
      mq = bnd ? 0 : mq + 1;
    end
  endtask

  // Called at a falling edge with inputs set: check, clock, update.
  task automatic run_cycle();
    #2;
    check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    checks = 0; failures = 0; done = 1'b0;
    mp = 0; mq = 0; m_tsh = 8'hFF; m_thold = 8'hFF; m_rsh = 8'hFF; m_robuf = 8'hFF;
    m_tccs = 0; m_tsrc = 0; m_rccs = 0;
    tx_stalled = 0; rx_stalled = 0; tx_after_sync = 0; rx_after_sync = 0;
    tx_frame = 0; rx_frame = 0;
    rst_n = 1'b0; ccs_en = 1'b1; ser_src_sel = 1'b1; sys_ce = 1'b0; rec_ce = 1'b0;
    tx_frame_sync = 1'b0; rx_frame_sync = 1'b0; tx_main_in = 1'b0;
    tx_ser_in = 1'b0; rx_line_in = 1'b0;

    // R1: reset state, both main-stream values
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tx_main_in = i[0];
      #2;
      check1("R1", tx_ck64, 1'b1);
      check1("R1", rx_ck64, 1'b1);
      check1("R1", rx_ser_out, 1'b1);
      check1("R1", tx_line_out, tx_main_in);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tx_main_in = ~i[0];
      #2;
      check1("R1", tx_ck64, 1'b1);
      check1("R1", rx_ser_out, 1'b1);
      check1("R1", tx_line_out, tx_main_in);
      @(negedge clk);
    end

    // Phase A: every serial byte value, mid-frame mode changes.
    sys_ce = 1'b1; rec_ce = 1'b1;
    for (int c = 0; c < 256 * 512; c++) begin
      logic [7:0] tb_byte, rb_byte;
      tb_byte = 8'(tx_frame);
      rb_byte = 8'(rx_frame * 29 + 7);
      if (mp == 100) begin
        ccs_en      = (tx_frame % 5) != 2;
        ser_src_sel = (tx_frame % 7) != 4;
      end
      tx_ser_in  = tb_byte[7 - (mp >> 6)];
      tx_main_in = hbit(c, 17);
      rx_line_in = (mq >= 128 && mq < 136) ? rb_byte[7 - (mq - 128)] : hbit(c, 9);
      run_cycle();
    end

    // Phase B: gated enables and mid-frame realignment on both sides.
    for (int c = 1; c <= 4000; c++) begin
      sys_ce        = (c % 3) != 0;
      rec_ce        = (c % 4) != 1;
      tx_frame_sync = (c == 700) || (c == 2222);
      rx_frame_sync = (c == 450) || (c == 1900);
      if ((c % 97) == 0) begin
        ccs_en      = hbit(c, 3) | hbit(c, 11);
        ser_src_sel = hbit(c, 5) | hbit(c, 21);
      end
      tx_ser_in  = hbit(c, 13);
      tx_main_in = hbit(c, 19);
      rx_line_in = hbit(c, 7);
      run_cycle();
    end
    tx_frame_sync = 1'b0; rx_frame_sync = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule